// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital control section of a 32-tap digitally controlled potentiometer. Three slow control lines from a host are taken in through two-flop synchronizers: an active-low chip select, a direction line and an increment strobe. While the chip is selected, each falling edge of the increment strobe moves a saturating tap counter up or down by one step. The counter is decoded into a one-hot tap-select vector that drives the switch network of the resistor array.

When the host releases chip select, the level of the increment strobe at that moment chooses the outcome. If the strobe is high, the position is committed to a modelled nonvolatile copy. This starts a store cycle that lasts a parameterised number of clocks, and a busy flag is raised for its whole length. If the strobe is low, nothing is stored and the working position is kept. A functional reset stands in for power-up and reloads the working position from the nonvolatile copy. A standby flag reports when the block is neither selected nor storing.

Top module: `wiper_ctl`

## Requirements
- R1: `tap_sel_o` always has exactly one bit set. That bit is bit `pos_o`, where `pos_o` is the binary tap index from 0 to TAPS-1.
- R2: The position changes only on a falling edge of `step_i` while the block is selected and not busy. A rising edge, or any edge while deselected, leaves it unchanged.
- R3: On a counting edge, the position rises by one when `dir_i` is 1 and falls by one when `dir_i` is 0. `dir_i` may change while the block stays selected, and the next edge uses the new level.
- R4: The counter saturates. Stepping up at TAPS-1 stays at TAPS-1, and stepping down at 0 stays at 0.
- R5: A rising edge of `sel_n_i` while selected, with `step_i` high, starts a store. `busy_o` is high for exactly STORE_CYCLES clock cycles, and the position is written to the nonvolatile copy when the cycle ends.
- R6: A rising edge of `sel_n_i` while selected, with `step_i` low, stores nothing. `busy_o` stays 0 and the working position is kept.
- R7: Reset loads the working position from the nonvolatile copy. Reset does not clear that copy, whose power-on value is tap 0. The copy changes only when a store cycle completes, so a reset during a store leaves the old value.
- R8: `standby_o` is 1 when the block is neither selected nor busy. After a store it stays 1 until a new selection begins.
- R9: While busy, increment edges are ignored and a falling edge of `sel_n_i` is ignored. A selection begun during a store takes effect only after `sel_n_i` goes high and low again. A release from such an ignored selection stores nothing.
- R10: Each input passes through two synchronizing flops. A step on `step_i` driven between clock edges shows on `pos_o` after the third following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up stand-in) |
| sel_n_i | input | 1 | Active-low chip select, asynchronous |
| dir_i | input | 1 | Direction: 1 counts up, 0 counts down |
| step_i | input | 1 | Increment strobe, acts on its falling edge |
| tap_sel_o | output | TAPS | One-hot tap select |
| pos_o | output | $clog2(TAPS) | Current tap index |
| busy_o | output | 1 | Store cycle in progress |
| standby_o | output | 1 | Deselected and idle |

## Verification
The bench builds the block with TAPS=32 and STORE_CYCLES=40. At that store length, the bench can measure the whole busy window cycle by cycle and can place a reselection and increment pulses inside it. Thirty-two taps let both saturation ends be reached within a few dozen pulses. The nonvolatile contents are observed through the position that reset reloads.

// File: rtl/wiper_ctl.sv
module wiper_ctl #(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 1_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n_i,
  input  logic                    dir_i,
  input  logic                    step_i,
  output logic [TAPS-1:0]         tap_sel_o,
  output logic [$clog2(TAPS)-1:0] pos_o,
  output logic                    busy_o,
  output logic                    standby_o
);
  localparam int PW = $clog2(TAPS);
  localparam int CW = $clog2(STORE_CYCLES + 1);
  localparam logic [PW-1:0] TOP = PW'(TAPS - 1);

  // [0] first stage, [1] synchronized level, [2] previous synchronized level
  logic [2:0] sel_sh, step_sh;
  logic [1:0] dir_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_sh  <= 3'b111;
      step_sh <= 3'b111;
      dir_sh  <= 2'b00;
    end else begin
      sel_sh  <= {sel_sh[1:0], sel_n_i};
      step_sh <= {step_sh[1:0], step_i};
      dir_sh  <= {dir_sh[0], dir_i};
    end
  end

  wire sel_rise  = sel_sh[1] & ~sel_sh[2];
  wire sel_fall  = ~sel_sh[1] & sel_sh[2];
  wire step_fall = ~step_sh[1] & step_sh[2];
  wire step_lvl  = step_sh[1];
  wire dir_up    = dir_sh[1];

  logic [PW-1:0] pos_q;
  logic [PW-1:0] nv_q = '0;
  logic          active_q, busy_q;
  logic [CW-1:0] cnt_q;

  wire do_step    = active_q & ~busy_q & step_fall;
  wire do_store   = active_q & ~busy_q & sel_rise & step_lvl;
  wire store_done = busy_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pos_q <= nv_q;
    else if (do_step) begin
      if (dir_up && pos_q != TOP)
        pos_q <= pos_q + 1'b1;
      else if (!dir_up && pos_q != '0)
        pos_q <= pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      active_q <= 1'b0;
    else if (sel_rise)
      active_q <= 1'b0;
    else if (sel_fall && !busy_q)
      active_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (do_store) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(STORE_CYCLES - 1);
    end else if (store_done)
      busy_q <= 1'b0;
    else if (busy_q)
      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk)
    if (rst_n && store_done)
      nv_q <= pos_q;

  for (genvar i = 0; i < TAPS; i++) begin : g_dec
    assign tap_sel_o[i] = (pos_q == PW'(i));
  end

  assign pos_o     = pos_q;
  assign busy_o    = busy_q;
  assign standby_o = ~active_q & ~busy_q;

  // R1
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel_o) == 1 && tap_sel_o[pos_o]);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q || busy_q) |=> $stable(pos_q));

  // R4
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == TOP) |=> (pos_q != '0));

  // R4
  no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) |=> (pos_q != TOP));

  // R7
  nv_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(nv_q));

  // R6
  no_store_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && sel_rise && !step_lvl) |=> !busy_q);

  // R9
  no_select_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !active_q);

  // R8
  standby_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> standby_o);
endmodule

// File: tb/wiper_ctl_tb.sv
`timescale 1ns/1ps
module wiper_ctl_tb;
  localparam int TAPS = 32;
  localparam int STORE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n_i = 1'b1, dir_i = 1'b0, step_i = 1'b1;
  logic [TAPS-1:0] tap_sel_o;
  logic [4:0] pos_o;
  logic busy_o, standby_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_ctl #(.TAPS(TAPS), .STORE_CYCLES(STORE)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .dir_i(dir_i), .step_i(step_i),
    .tap_sel_o(tap_sel_o), .pos_o(pos_o), .busy_o(busy_o), .standby_o(standby_o));

  // {dir, expected position} starting from tap 0
  localparam logic [5:0] VECS [12] = '{
    {1'b0, 5'd0}, {1'b1, 5'd1}, {1'b1, 5'd2}, {1'b1, 5'd3},
    {1'b0, 5'd2}, {1'b1, 5'd3}, {1'b1, 5'd4}, {1'b0, 5'd3},
    {1'b0, 5'd2}, {1'b0, 5'd1}, {1'b0, 5'd0}, {1'b0, 5'd0}};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    step_i = 1'b0; wait_n(5);
    step_i = 1'b1; wait_n(5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_n(4);
    rst_n = 1'b1; wait_n(4);
  endtask

  initial begin
    int busy_cnt;
    wait_n(2);
    do_reset();
    // R7 power-on copy is tap 0; R1 decode; R8 standby
    chk("R7 reset pos", pos_o, 0);
    chk("R1 tap one-hot", tap_sel_o, 32'd1);
    chk("R5 busy idle", busy_o, 0);
    chk("R8 standby after reset", standby_o, 1);

    sel_n_i = 1'b0; wait_n(6);
    chk("R8 standby low when selected", standby_o, 0);
    for (int i = 0; i < 12; i++) begin
      dir_i = VECS[i][5]; wait_n(3);
      pulse();
      chk("R3 table pos", pos_o, VECS[i][4:0]);
      chk("R1 table decode", tap_sel_o, 32'd1 << VECS[i][4:0]);
    end

    // R6 release with strobe low
    step_i = 1'b0; wait_n(6);
    sel_n_i = 1'b1; wait_n(6);
    chk("R6 no busy", busy_o, 0);
    chk("R6 pos kept", pos_o, 0);
    step_i = 1'b1; wait_n(6);
    dir_i = 1'b1;
    pulse(); pulse();
    chk("R2 deselected steps ignored", pos_o, 0);

    // R4 top saturation
    sel_n_i = 1'b0; wait_n(6);
    for (int i = 0; i < 35; i++) pulse();
    chk("R4 top saturation", pos_o, 31);
    chk("R1 decode at top", tap_sel_o, 32'h8000_0000);
    dir_i = 1'b0; wait_n(3);
    for (int i = 0; i < 14; i++) pulse();
    chk("R3 down to 17", pos_o, 17);

    // R5 store, with R9 reselection and steps during busy
    busy_cnt = 0;
    @(negedge clk); sel_n_i = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (busy_o) busy_cnt++;
      if (i == 8) sel_n_i = 1'b0;
      if (i == 14) step_i = 1'b0;
      if (i == 20) chk("R5 busy mid store", busy_o, 1);
      if (i == 22) step_i = 1'b1;
    end
    chk("R5 busy length", busy_cnt, STORE);
    chk("R9 pos unchanged during busy", pos_o, 17);
    chk("R9 selection during busy ignored", standby_o, 1);
    pulse();
    chk("R9 steps after busy w/o reselect", pos_o, 17);
    sel_n_i = 1'b1; wait_n(10);
    chk("R9 release of ignored select no store", busy_o, 0);
    sel_n_i = 1'b0; wait_n(6);
    pulse();
    chk("R9 reselect works", pos_o, 16);
    step_i = 1'b0; wait_n(6);
    sel_n_i = 1'b1; wait_n(6);
    step_i = 1'b1; wait_n(4);
    chk("R6 no busy second", busy_o, 0);
    do_reset();
    chk("R7 reload stored tap", pos_o, 17);

    // R7 reset during store aborts it
    sel_n_i = 1'b0; wait_n(6);
    dir_i = 1'b1; wait_n(3);
    pulse();
    chk("R3 up to 18", pos_o, 18);
    sel_n_i = 1'b1; wait_n(8);
    chk("R5 busy started", busy_o, 1);
    do_reset();
    chk("R7 aborted store keeps old copy", pos_o, 17);
    chk("R7 busy cleared", busy_o, 0);

    // R10 synchronizer latency
    sel_n_i = 1'b0; wait_n(6);
    @(negedge clk); step_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no change after two edges", pos_o, 17);
    @(negedge clk);
    chk("R10 change after third edge", pos_o, 18);
    step_i = 1'b1; wait_n(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule